// File: doc/BRIEF.md
# Periodic Whole-Second Drift Trimmer

This block sits next to a seconds counter and corrects slow frequency drift by adjusting whole seconds. Once per programmed period of once-per-second ticks it either removes one second (the counter does not advance on the following tick) or adds one (the counter advances by two). A period of P ticks gives a trim of about 1e9/P parts per billion, in whichever direction is chosen.

Software programs the trim through a single 32-bit configuration word, which holds a period match count, a two-bit direction code and an enable flag. The block counts ticks against the match count. When the period completes, it raises a pending request that tells the neighbouring seconds counter how to treat its next increment. For every tick it also reports the step (0, 1 or 2) that the counter should apply. The block does not keep time itself, and it does not convert a ppb figure into register fields.

Top module: `sec_trim`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `skip_o`, `dbl_o` and `step_vld_o` are 0, and the trim is disabled (enable flag 0).
- R2: The configuration word is decoded as follows. The match count is bits 18:0, the direction code is bits 20:19, and the enable flag is bit 23. Bits 22:21 and 31:24 have no effect on behaviour.
- R3: Trimming is active only when the enable flag is 1 and the direction code is 2 or 3. Otherwise no request is ever raised, and every tick reports a step of 1.
- R4: While the trim is active with match count M, an internal period count starts at 0 after a write and advances by one on each tick. On the tick where it equals M, it raises a request and wraps to 0. The request therefore comes on ticks M+1, 2(M+1), and so on after the write.
- R5: Direction code 2 raises `skip_o`, and direction code 3 raises `dbl_o`. The request is held until the next tick consumes it. Without a tick or a write it does not change.
- R6: In the cycle after each tick, `step_vld_o` is 1 for one cycle. `step_o` is then 0 if `skip_o` was set when the tick arrived, 2 if `dbl_o` was set, and 1 otherwise. Without a tick, `step_vld_o` stays 0.
- R7: A write resets the period count to 0 and clears any pending request. A tick in the same cycle as a write still reports its step from the request that was pending before the write.
- R8: A match count of 0 raises a request on every tick, so the request stays asserted across consecutive ticks and every step after the first is trimmed.
- R9: `skip_o` and `dbl_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word: match count, direction code, enable flag |
| skip_o | output | 1 | Next increment of the seconds counter is to be suppressed |
| dbl_o | output | 1 | Next increment of the seconds counter is to be doubled |
| step_o | output | 2 | Step to apply for the tick just seen (0, 1 or 2) |
| step_vld_o | output | 1 | `step_o` is valid this cycle |

## Verification
The properties assume that `tick_i` and `cfg_we_i` are synchronous to `clk` and hold known values once reset has been released. They make no assumption about how far apart ticks are. The stimulus drives every input on the falling edge and uses single-cycle tick pulses, usually with idle cycles between them. Two places deliberately break that spacing: ticks on adjacent cycles under a zero match count, and a tick in the same cycle as a write. Both exercise the consume-and-rearm path and the priority of a write over the period state.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

    localparam int unsigned CFG_W        = 32;
    localparam int unsigned DEF_MATCH_W  = 19;

    // direction codes carried in the configuration word
    typedef enum logic [1:0] {
        DIR_OFF_A   = 2'd0,
        DIR_OFF_B   = 2'd1,
        DIR_SWALLOW = 2'd2,
        DIR_INSERT  = 2'd3
    } trim_dir_e;

    // state of the request handed to the seconds counter
    typedef enum logic [1:0] {
        PEND_NONE   = 2'd0,
        PEND_SKIP   = 2'd1,
        PEND_DOUBLE = 2'd2
    } pend_e;

    typedef struct packed {
        logic  active;
        pend_e kind;
    } trim_mode_t;

    localparam logic [1:0] STEP_SKIP   = 2'd0;
    localparam logic [1:0] STEP_NORMAL = 2'd1;
    localparam logic [1:0] STEP_DOUBLE = 2'd2;

    function automatic trim_mode_t decode_mode(input logic en, input trim_dir_e dir);
        trim_mode_t m;
        m.active = en && (dir == DIR_SWALLOW || dir == DIR_INSERT);
        m.kind   = (dir == DIR_INSERT) ? PEND_DOUBLE : PEND_SKIP;
        return m;
    endfunction

    function automatic logic [1:0] step_for(input pend_e p);
        logic [1:0] s;
        case (p)
            PEND_SKIP:   s = STEP_SKIP;
            PEND_DOUBLE: s = STEP_DOUBLE;
            default:     s = STEP_NORMAL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sec_trim_cfg.sv
module sec_trim_cfg
    import sec_trim_pkg::*;
#(
    parameter int unsigned MATCH_W = DEF_MATCH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [CFG_W-1:0]   wdata_i,
    output logic [MATCH_W-1:0] match_o,
    output trim_mode_t         mode_o
);
    localparam int unsigned DIR_LSB = MATCH_W;
    localparam int unsigned EN_POS  = MATCH_W + 4;

    logic [MATCH_W-1:0] match_q;
    trim_dir_e          dir_q;
    logic               en_q;
    logic               wr_unused_bits;

    assign wr_unused_bits = ^{wdata_i[CFG_W-1:EN_POS+1], wdata_i[EN_POS-1:DIR_LSB+2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            dir_q   <= DIR_OFF_A;
            en_q    <= 1'b0;
        end else if (we_i) begin
            match_q <= wdata_i[MATCH_W-1:0];
            dir_q   <= trim_dir_e'(wdata_i[DIR_LSB+1:DIR_LSB]);
            en_q    <= wdata_i[EN_POS];
        end
    end

    assign match_o = match_q;
    assign mode_o  = decode_mode(en_q, dir_q);

endmodule

// File: rtl/sec_trim_period.sv
module sec_trim_period #(
    parameter int unsigned MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart_i,
    input  logic               tick_i,
    input  logic               active_i,
    input  logic [MATCH_W-1:0] match_i,
    output logic               fire_o
);
    logic [MATCH_W-1:0] cnt_q;
    logic               at_match;

    assign at_match = (cnt_q == match_i);
    assign fire_o   = tick_i && active_i && at_match && !restart_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i || !active_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_match ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sec_trim_step.sv
module sec_trim_step
    import sec_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_i,
    input  logic       tick_i,
    input  logic       fire_i,
    input  pend_e      kind_i,
    output logic       skip_o,
    output logic       dbl_o,
    output logic [1:0] step_o,
    output logic       step_vld_o
);
    pend_e      pend_q;
    pend_e      pend_d;
    logic [1:0] step_q;
    logic       vld_q;

    always_comb begin
        pend_d = pend_q;
        if (restart_i)   pend_d = PEND_NONE;
        else if (fire_i) pend_d = kind_i;
        else if (tick_i) pend_d = PEND_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= PEND_NONE;
            step_q <= STEP_NORMAL;
            vld_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            vld_q  <= tick_i;
            if (tick_i) step_q <= step_for(pend_q);
        end
    end

    assign skip_o     = (pend_q == PEND_SKIP);
    assign dbl_o      = (pend_q == PEND_DOUBLE);
    assign step_o     = step_q;
    assign step_vld_o = vld_q;

endmodule

// File: rtl/sec_trim.sv
module sec_trim
    import sec_trim_pkg::*;
#(
    parameter int unsigned MATCH_W = DEF_MATCH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             skip_o,
    output logic             dbl_o,
    output logic [1:0]       step_o,
    output logic             step_vld_o
);
    logic [MATCH_W-1:0] match;
    trim_mode_t         mode;
    logic               fire;

    sec_trim_cfg #(.MATCH_W(MATCH_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .match_o (match),
        .mode_o  (mode)
    );

    sec_trim_period #(.MATCH_W(MATCH_W)) u_period (
        .clk       (clk),
        .rst       (rst),
        .restart_i (cfg_we_i),
        .tick_i    (tick_i),
        .active_i  (mode.active),
        .match_i   (match),
        .fire_o    (fire)
    );

    sec_trim_step u_step (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (cfg_we_i),
        .tick_i     (tick_i),
        .fire_i     (fire),
        .kind_i     (mode.kind),
        .skip_o     (skip_o),
        .dbl_o      (dbl_o),
        .step_o     (step_o),
        .step_vld_o (step_vld_o)
    );

endmodule

// File: rtl/sec_trim_chk.sv
module sec_trim_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       cfg_we_i,
    input logic       skip_o,
    input logic       dbl_o,
    input logic [1:0] step_o,
    input logic       step_vld_o
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(skip_o && dbl_o)); // R9

    AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> step_vld_o); // R6

    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !step_vld_o); // R6

    AST_STEP_SKIP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && skip_o) |=> (step_o == 2'd0)); // R6

    AST_STEP_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (tick_i && dbl_o) |=> (step_o == 2'd2)); // R6

    AST_STEP_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !skip_o && !dbl_o) |=> (step_o == 2'd1)); // R6

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_we_i |=> (!skip_o && !dbl_o)); // R7

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !cfg_we_i) |=> ($stable(skip_o) && $stable(dbl_o))); // R5

endmodule

bind sec_trim sec_trim_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .cfg_we_i   (cfg_we_i),
    .skip_o     (skip_o),
    .dbl_o      (dbl_o),
    .step_o     (step_o),
    .step_vld_o (step_vld_o)
);

// File: tb/tb_sec_trim.sv
module tb_sec_trim;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0;
    logic        skip_o, dbl_o, step_vld_o;
    logic [1:0]  step_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model, written from the requirements
    int unsigned m_match = 0;
    int unsigned m_cnt   = 0;
    int          m_dir   = 0;
    bit          m_en    = 0;
    int          m_pend  = 0;   // 0 none, 1 skip, 2 double
    int          exp_q[$];

    always #10 clk = ~clk;

    sec_trim dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i), .skip_o(skip_o), .dbl_o(dbl_o),
        .step_o(step_o), .step_vld_o(step_vld_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_active();
        return m_en && (m_dir == 2 || m_dir == 3);
    endfunction

    function automatic int step_of(input int p);
        return (p == 1) ? 0 : (p == 2) ? 2 : 1;
    endfunction

    function automatic void model_tick();
        exp_q.push_back(step_of(m_pend));
        if (m_active()) begin
            if (m_cnt == m_match) begin
                m_cnt  = 0;
                m_pend = (m_dir == 3) ? 2 : 1;
            end else begin
                m_cnt++;
                m_pend = 0;
            end
        end else begin
            m_cnt  = 0;
            m_pend = 0;
        end
    endfunction

    function automatic void model_write(input logic [31:0] d);
        m_match = d[18:0];
        m_dir   = int'(d[20:19]);
        m_en    = d[23];
        m_cnt   = 0;
        m_pend  = 0;
    endfunction

    task automatic check_levels(input string req);
        check({req, " skip_o"}, int'(skip_o), int'(m_pend == 1));
        check({req, " dbl_o"},  int'(dbl_o),  int'(m_pend == 2));
        check("R9 exclusive", int'(skip_o && dbl_o), 0);
    endtask

    function automatic logic [31:0] cfg(input bit en, input int dir, input int unsigned m);
        return (32'(en) << 23) | (32'(dir & 3) << 19) | (m & 32'h7FFFF);
    endfunction

    task automatic write_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = d;
        model_write(d);
        @(negedge clk);
        cfg_we_i = 1'b0;
        check_levels("R7 after write");
    endtask

    task automatic tick_n(input int n, input int gap, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            model_tick();
            @(negedge clk);
            tick_i = 1'b0;
            check_levels(req);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic write_with_tick(input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = d; tick_i = 1'b1;
        model_tick();
        model_write(d);
        @(negedge clk);
        cfg_we_i = 1'b0; tick_i = 1'b0;
        check_levels("R7 write with tick");
    endtask

    // monitor: scoreboard of reported steps (R6)
    always @(negedge clk) begin
        if (!rst && step_vld_o) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected step_vld_o", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R6 step_o", int'(step_o), e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 skip_o in reset", int'(skip_o), 0);
        check("R1 dbl_o in reset", int'(dbl_o), 0);
        check("R1 step_vld_o in reset", int'(step_vld_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 step_vld_o after reset", int'(step_vld_o), 0);
        check_levels("R1");

        // disabled after reset: plain steps
        tick_n(4, 1, "R3 reset config");

        // swallow every 4th tick
        write_cfg(cfg(1, 2, 3));
        tick_n(10, 2, "R4 R5 swallow period");

        // insert every 3rd tick, reserved bits set
        write_cfg(cfg(1, 3, 2) | 32'hFF60_0000);
        tick_n(8, 1, "R2 insert with reserved bits");

        // direction codes 0 and 1 are inert even when enabled
        write_cfg(cfg(1, 0, 0));
        tick_n(4, 1, "R3 dir 0");
        write_cfg(cfg(1, 1, 1));
        tick_n(4, 1, "R3 dir 1");

        // enable flag clear with valid direction
        write_cfg(cfg(0, 3, 0));
        tick_n(4, 1, "R3 enable clear");

        // match 0, back-to-back ticks
        write_cfg(cfg(1, 3, 0));
        tick_n(6, 0, "R8 insert every tick");
        write_cfg(cfg(1, 2, 0));
        tick_n(5, 0, "R8 swallow every tick");

        // rewrite mid-period restarts the count
        write_cfg(cfg(1, 2, 4));
        tick_n(3, 1, "R7 partial period");
        write_cfg(cfg(1, 2, 4));
        tick_n(6, 1, "R7 restarted period");

        // rewrite while a request is pending, and with a coincident tick
        write_cfg(cfg(1, 3, 1));
        tick_n(2, 1, "R5 pending before rewrite");
        write_with_tick(cfg(1, 3, 1));
        tick_n(5, 1, "R7 after coincident write");
        tick_n(1, 0, "R5 pending armed");
        repeat (5) @(negedge clk);
        check_levels("R5 held while idle");
        write_with_tick(cfg(1, 2, 2));
        tick_n(6, 1, "R4 after coincident write");

        repeat (4) @(negedge clk);
        check("R6 all steps reported", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule